// File: doc/BRIEF.md
# Spin-Lock Acquirer with Exponential Back-Off

This block acquires a shared lock word in memory on behalf of one processor. On an acquisition request it latches the lock address. It polls the word with plain reads until it sees zero, and only then issues an atomic test-and-set. Any check that finds the lock taken counts as a failure. This covers a read returning nonzero and a test-and-set returning a nonzero old value. After a failure the engine stays off the memory port for a back-off interval. The interval begins at one cycle and doubles with every failure, up to a parameter cap. Uncontended locks are therefore taken within a few cycles, while heavily contended locks see few polls.

Once a test-and-set returns zero, the engine raises `acquired` and holds it until the processor asks for a release. A release stores zero to the lock word and returns the engine to idle. The engine reports how many test-and-set attempts the most recent acquisition needed. Memory traffic uses a simple handshake: the engine holds a request, with its operation and address steady, until the memory returns a response.

Top module: `lock_acquire_engine`

## Requirements
- R1: After reset `acquired`, `mem_req` and `rel_err` are 0, and `attempt_cnt` is 0.
- R2: An `acq_req` seen in idle latches `acq_addr` and starts a read (op 0). Every request carries the latched address. A request stays asserted, with op and address unchanged, until the cycle in which `mem_rsp_valid` is 1.
- R3: A read response of zero is followed directly by a test-and-set (op 1) to the same address. A read response that is nonzero is a failure. A test-and-set is issued only immediately after a read that returned zero.
- R4: A test-and-set response of zero makes `acquired` 1 from the next cycle until release, with no memory request during that time. A nonzero test-and-set response is a failure, followed by back-off and then reads.
- R5: After a failure response, `mem_req` stays 0 for exactly the current delay in cycles before the next read. The delay is 1 after reset and doubles after each failure.
- R6: The delay never exceeds `DELAY_MAX`. Once doubling would pass the cap, the delay stays at `DELAY_MAX`.
- R7: The delay returns to 1 whenever the lock is acquired, so the next acquisition starts with a 1-cycle back-off.
- R8: `attempt_cnt` counts the test-and-set responses of the current acquisition. It clears when an acquisition starts and holds its value after `acquired` rises.
- R9: A `rel_req` while `acquired` is 1 lowers `acquired` in the next cycle and issues a store of zero (op 2) to the latched address. After its response the engine is idle.
- R10: A `rel_req` while `acquired` is 0 causes no memory request and does not change the acquisition in progress. It produces `rel_err` = 1 in the next cycle only.
- R11: An `acq_req` while an acquisition is in progress or the lock is held is ignored, and the latched address is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | 1 | Start an acquisition (taken in idle only) |
| acq_addr | input | ADDR_W | Lock word address, latched with `acq_req` |
| rel_req | input | 1 | Release the held lock |
| acquired | output | 1 | Lock is held |
| rel_err | output | 1 | One-cycle pulse: release asked while not holding |
| attempt_cnt | output | CNT_W | Test-and-set attempts of the latest acquisition |
| mem_req | output | 1 | Memory request valid |
| mem_op | output | 2 | 0 read, 1 test-and-set, 2 store zero |
| mem_addr | output | ADDR_W | Memory request address |
| mem_rsp_valid | input | 1 | Memory response, completes the request |
| mem_rsp_data | input | DATA_W | Old lock value returned by read or test-and-set |

## Verification
A wrong control state shows up on the memory port in the cycle after the response that caused it. Symptoms include a test-and-set that no zero read preceded, a request during the hold, or `acquired` rising without a winning test-and-set. A wrong delay register shows up as an idle gap of the wrong length between a failure response and the next read. These gaps are measured in cycles against 1, 2, 4, and so on, saturating at the cap, so a single bad doubling or a missed reset after acquisition changes the total gap of that same acquisition. A corrupted attempt counter or latched address appears at `attempt_cnt` when `acquired` rises, or on the release store.

// File: rtl/lae_pkg.sv
package lae_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ_SPIN = 3'd1,
        ST_TAS       = 3'd2,
        ST_BACKOFF   = 3'd3,
        ST_HELD      = 3'd4,
        ST_RELEASE   = 3'd5
    } lae_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_TAS   = 2'd1,
        OP_WZERO = 2'd2
    } lae_op_e;

endpackage

// File: rtl/lae_backoff.sv
// Back-off delay register and countdown timer.
module lae_backoff #(
    parameter int DELAY_MAX = 1024,
    parameter int DLY_W     = $clog2(DELAY_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail_i,   // failed check: start wait, double delay
    input  logic             clear_i,  // lock taken: delay back to 1
    output logic             expire_o, // last cycle of the wait
    output logic [DLY_W-1:0] delay_o
);

    localparam logic [DLY_W-1:0] MAX_V = DLY_W'(DELAY_MAX);
    localparam logic [DLY_W-1:0] ONE_V = DLY_W'(1);

    typedef struct packed {
        logic [DLY_W-1:0] delay;
        logic [DLY_W-1:0] cnt;
    } bo_s;

    bo_s            st_d, st_q;
    logic [DLY_W:0] dbl;

    always_comb begin
        st_d = st_q;
        dbl  = {st_q.delay, 1'b0};
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE_V;
        end
        if (fail_i) begin
            st_d.cnt = st_q.delay;
            if (dbl > {1'b0, MAX_V}) begin
                st_d.delay = MAX_V;
            end else begin
                st_d.delay = dbl[DLY_W-1:0];
            end
        end
        if (clear_i) begin
            st_d.delay = ONE_V;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.delay <= ONE_V;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire_o = (st_q.cnt == ONE_V);
    assign delay_o  = st_q.delay;

endmodule

// File: rtl/lae_attempts.sv
// Saturating counter of test-and-set attempts.
module lae_attempts #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } att_s;

    att_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.count = '0;
        end else if (inc_i && (st_q.count != '1)) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.count <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/lae_ctrl.sv
// Test-and-test-and-set sequencer.
module lae_ctrl
    import lae_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_req_i,
    input  logic [ADDR_W-1:0] acq_addr_i,
    input  logic              rel_req_i,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              expire_i,
    output logic              mem_req_o,
    output logic [1:0]        mem_op_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              acquired_o,
    output logic              rel_err_o,
    output logic              bo_fail_o,
    output logic              bo_clear_o,
    output logic              att_clear_o,
    output logic              att_inc_o
);

    typedef struct packed {
        lae_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic  lock_free;

    assign lock_free = (rsp_data_i == '0);

    always_comb begin
        st_d        = st_q;
        st_d.err    = 1'b0;
        bo_fail_o   = 1'b0;
        bo_clear_o  = 1'b0;
        att_clear_o = 1'b0;
        att_inc_o   = 1'b0;

        if (rel_req_i && (st_q.state != ST_HELD)) begin
            st_d.err = 1'b1;
        end

        unique case (st_q.state)
            ST_IDLE: begin
                if (acq_req_i) begin
                    st_d.addr   = acq_addr_i;
                    st_d.state  = ST_READ_SPIN;
                    att_clear_o = 1'b1;
                end
            end
            ST_READ_SPIN: begin
                if (rsp_valid_i) begin
                    if (lock_free) begin
                        st_d.state = ST_TAS;
                    end else begin
                        bo_fail_o  = 1'b1;
                        st_d.state = ST_BACKOFF;
                    end
                end
            end
            ST_TAS: begin
                if (rsp_valid_i) begin
                    att_inc_o = 1'b1;
                    if (lock_free) begin
                        bo_clear_o = 1'b1;
                        st_d.state = ST_HELD;
                    end else begin
                        bo_fail_o  = 1'b1;
                        st_d.state = ST_BACKOFF;
                    end
                end
            end
            ST_BACKOFF: begin
                if (expire_i) begin
                    st_d.state = ST_READ_SPIN;
                end
            end
            ST_HELD: begin
                if (rel_req_i) begin
                    st_d.state = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (rsp_valid_i) begin
                    st_d.state = ST_IDLE;
                end
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.addr  <= '0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_req_o = 1'b0;
        mem_op_o  = OP_READ;
        unique case (st_q.state)
            ST_READ_SPIN: begin
                mem_req_o = 1'b1;
                mem_op_o  = OP_READ;
            end
            ST_TAS: begin
                mem_req_o = 1'b1;
                mem_op_o  = OP_TAS;
            end
            ST_RELEASE: begin
                mem_req_o = 1'b1;
                mem_op_o  = OP_WZERO;
            end
            default: begin
                mem_req_o = 1'b0;
                mem_op_o  = OP_READ;
            end
        endcase
    end

    assign mem_addr_o = st_q.addr;
    assign acquired_o = (st_q.state == ST_HELD);
    assign rel_err_o  = st_q.err;

endmodule

// File: rtl/lock_acquire_engine.sv
module lock_acquire_engine #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int DELAY_MAX = 1024,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_req,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic              rel_req,
    output logic              acquired,
    output logic              rel_err,
    output logic [CNT_W-1:0]  attempt_cnt,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    localparam int DLY_W = $clog2(DELAY_MAX + 1);

    logic             bo_fail;
    logic             bo_clear;
    logic             bo_expire;
    logic [DLY_W-1:0] cur_delay;
    logic             att_clear;
    logic             att_inc;

    lae_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .acq_req_i   (acq_req),
        .acq_addr_i  (acq_addr),
        .rel_req_i   (rel_req),
        .rsp_valid_i (mem_rsp_valid),
        .rsp_data_i  (mem_rsp_data),
        .expire_i    (bo_expire),
        .mem_req_o   (mem_req),
        .mem_op_o    (mem_op),
        .mem_addr_o  (mem_addr),
        .acquired_o  (acquired),
        .rel_err_o   (rel_err),
        .bo_fail_o   (bo_fail),
        .bo_clear_o  (bo_clear),
        .att_clear_o (att_clear),
        .att_inc_o   (att_inc)
    );

    lae_backoff #(
        .DELAY_MAX (DELAY_MAX),
        .DLY_W     (DLY_W)
    ) u_backoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .fail_i   (bo_fail),
        .clear_i  (bo_clear),
        .expire_o (bo_expire),
        .delay_o  (cur_delay)
    );

    lae_attempts #(
        .CNT_W (CNT_W)
    ) u_attempts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (att_clear),
        .inc_i   (att_inc),
        .count_o (attempt_cnt)
    );

endmodule

// File: rtl/lae_checker.sv
module lae_checker
    import lae_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int DELAY_MAX = 1024,
    parameter int DLY_W     = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rel_req,
    input logic              acquired,
    input logic              rel_err,
    input logic              mem_req,
    input logic [1:0]        mem_op,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rsp_valid,
    input logic [DATA_W-1:0] mem_rsp_data,
    input logic [DLY_W-1:0]  cur_delay
);

    localparam logic [DLY_W-1:0] MAX_V = DLY_W'(DELAY_MAX);

    p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_op) && $stable(mem_addr)));

    p_tas_after_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_op == OP_TAS) && !$past(mem_req && (mem_op == OP_TAS)))
        |-> $past(mem_rsp_valid && (mem_op == OP_READ) && (mem_rsp_data == '0)));

    p_held_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acquired |-> !mem_req);

    p_acq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acquired) |-> $past(mem_rsp_valid && (mem_op == OP_TAS) && (mem_rsp_data == '0)));

    p_delay_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_delay != '0) && (cur_delay <= MAX_V));

    p_release_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_op == OP_WZERO))
        |-> ($past(acquired) || $past(mem_req && (mem_op == OP_WZERO))));

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> ($past(rel_req) && !$past(acquired)));

endmodule

bind lock_acquire_engine lae_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DELAY_MAX (DELAY_MAX),
    .DLY_W     (DLY_W)
) u_lae_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rel_req       (rel_req),
    .acquired      (acquired),
    .rel_err       (rel_err),
    .mem_req       (mem_req),
    .mem_op        (mem_op),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .cur_delay     (cur_delay)
);

// File: tb/lock_acquire_engine_tb_top.sv
module lock_acquire_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int DMAX       = 16;
    localparam int CNT_W      = 16;
    localparam int NVEC       = 8;
    localparam int WD_CYCLES  = 20000;

    // Bit i of a mask: 1 means the i-th memory response reports the lock taken.
    localparam logic [7:0] VEC_MASK [NVEC] = '{8'h00, 8'h01, 8'h02, 8'h07,
                                               8'h0A, 8'h1F, 8'h7F, 8'h01};
    localparam int VEC_ATT [NVEC] = '{1, 1, 2, 1, 3, 1, 1, 1};
    localparam int VEC_BO  [NVEC] = '{0, 1, 1, 7, 3, 31, 63, 1};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              acq_req;
    logic [ADDR_W-1:0] acq_addr;
    logic              rel_req;
    logic              acquired;
    logic              rel_err;
    logic [CNT_W-1:0]  attempt_cnt;
    logic              mem_req;
    logic [1:0]        mem_op;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rsp_valid;
    logic [DATA_W-1:0] mem_rsp_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lock_acquire_engine #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .DELAY_MAX (DMAX),
        .CNT_W     (CNT_W)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .acq_req       (acq_req),
        .acq_addr      (acq_addr),
        .rel_req       (rel_req),
        .acquired      (acquired),
        .rel_err       (rel_err),
        .attempt_cnt   (attempt_cnt),
        .mem_req       (mem_req),
        .mem_op        (mem_op),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Acquire with a scripted memory; measures idle gap cycles and TAS count.
    task automatic run_acq(input logic [7:0] mask, input logic [ADDR_W-1:0] addr,
                           input int exp_att, input int exp_bo, input bit poke_rel);
        int  idx = 0;
        int  bo = 0;
        int  tas_n = 0;
        int  bad_addr = 0;
        int  bad_op = 0;
        int  bad_tas = 0;
        bit  last_zero_read = 1'b0;
        bit  poked = 1'b0;
        bit  was;
        bit  bitv;
        @(negedge clk);
        acq_req  = 1'b1;
        acq_addr = addr;
        for (int it = 0; it < 5000; it++) begin
            @(negedge clk);
            acq_req = 1'b0;
            was = mem_rsp_valid;
            mem_rsp_valid = 1'b0;
            if (rel_req) begin
                rel_req = 1'b0;
                check(rel_err == 1'b1, "R10", "rel_err during back-off", rel_err, 1);
            end
            if (mem_req && !was) begin
                if (mem_addr != addr) bad_addr++;
                bitv = (idx < 8) ? mask[idx] : 1'b0;
                idx++;
                if (mem_op == 2'd1) begin
                    tas_n++;
                    if (!last_zero_read) bad_tas++;
                    last_zero_read = 1'b0;
                end else if (mem_op == 2'd0) begin
                    last_zero_read = !bitv;
                end else begin
                    bad_op++;
                end
                mem_rsp_data  = {{(DATA_W-1){1'b0}}, bitv};
                mem_rsp_valid = 1'b1;
            end else if (!mem_req && !acquired) begin
                bo++;
                if (poke_rel && !poked) begin
                    rel_req = 1'b1;
                    poked   = 1'b1;
                end
            end
            if (acquired) break;
        end
        check(acquired == 1'b1, "R4", "acquired after winning TAS", acquired, 1);
        check(bad_addr == 0, "R2", "requests with wrong address", bad_addr, 0);
        check(bad_op == 0, "R2", "unexpected op during acquire", bad_op, 0);
        check(bad_tas == 0, "R3", "TAS not preceded by zero read", bad_tas, 0);
        check(bo == exp_bo, "R5", "total back-off cycles (R6 cap)", bo, exp_bo);
        check(tas_n == exp_att, "R3", "TAS requests issued", tas_n, exp_att);
        check(int'(attempt_cnt) == exp_att, "R8", "attempt_cnt", attempt_cnt, exp_att);
    endtask

    task automatic do_release(input logic [ADDR_W-1:0] addr);
        @(negedge clk);
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        check(acquired == 1'b0, "R9", "acquired low in release", acquired, 0);
        check(mem_req == 1'b1 && mem_op == 2'd2, "R9", "store-zero op", mem_op, 2);
        check(mem_addr == addr, "R9", "release address", mem_addr, addr);
        mem_rsp_data  = '0;
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check(mem_req == 1'b0, "R9", "idle after release", mem_req, 0);
        check(rel_err == 1'b0, "R9", "no error on valid release", rel_err, 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, WD_CYCLES);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n         = 1'b0;
        acq_req       = 1'b0;
        acq_addr      = '0;
        rel_req       = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(acquired == 1'b0, "R1", "acquired", acquired, 0);
        check(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
        check(rel_err == 1'b0, "R1", "rel_err", rel_err, 0);
        check(attempt_cnt == '0, "R1", "attempt_cnt", attempt_cnt, 0);

        // R10: release while idle
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        check(rel_err == 1'b1, "R10", "rel_err pulse", rel_err, 1);
        check(mem_req == 1'b0, "R10", "no request on bad release", mem_req, 0);
        @(negedge clk);
        check(rel_err == 1'b0, "R10", "rel_err one cycle", rel_err, 0);

        // Table walk: R2..R8; the last entry (after a capped run) shows R7
        for (int i = 0; i < NVEC; i++) begin
            run_acq(VEC_MASK[i], ADDR_W'(32'h1000 + i * 4), VEC_ATT[i], VEC_BO[i], 1'b0);
            do_release(ADDR_W'(32'h1000 + i * 4));
        end

        // R10: release during back-off leaves the acquisition intact
        run_acq(8'h03, 32'h2000, 1, 3, 1'b1);

        // R11: acq_req while held is ignored and address kept
        @(negedge clk);
        acq_req  = 1'b1;
        acq_addr = 32'h3000;
        @(negedge clk);
        acq_req = 1'b0;
        check(mem_req == 1'b0, "R11", "no request while held", mem_req, 0);
        check(acquired == 1'b1, "R11", "still held", acquired, 1);
        do_release(32'h2000);

        // R7: first failure after that acquisition waits 1 cycle
        run_acq(8'h01, 32'h4000, 1, 1, 1'b0);
        do_release(32'h4000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule